// File: doc/BRIEF.md
# Multi-Rail Reset Sequencer with Margin Override

This block watches a set of power rails whose undervoltage state has already been digitized, one flag per rail. For each rail it drives a status output that is low while that rail is flagged and high again as soon as the rail recovers, with no stretching. It also drives one active-low system reset. That reset goes low when any rail is flagged or when the manual reset input is held low long enough to pass its glitch filter. It stays low for a programmable timeout after every cause has gone away.

Time for the reset timeout is counted in ticks of an internal prescaler, so both the tick length and the tick count are parameters. All asynchronous inputs pass through two-flop synchronizers.

A margin input supports supply-margin testing. While it is low, every output is held inactive (high). When it is released, the outputs keep that forced state for a fixed settling delay and then show their true values.

Top module: `rail_sup_top`

## Requirements
- R1: Within 4 clock cycles of any bit of `uv_i` going to 1 (1 = rail below threshold), `sys_rst_n_o` is 0.
- R2: Once all `uv_i` bits are 0 and the filtered manual reset is high, `sys_rst_n_o` stays 0 for at least TICK_DIV*TIMEOUT_TICKS clock cycles and rises no more than 8 cycles after that.
- R3: Each `rail_ok_o[i]` is 0 while `uv_i[i]` is 1 and is 1 while `uv_i[i]` is 0, both within 4 cycles, and with no timeout after recovery. Other rails are unaffected.
- R4: Within 4 cycles of `margin_n_i` going to 0, all `rail_ok_o` bits and `sys_rst_n_o` are 1, and they stay 1 whatever `uv_i` and `mrst_n_i` do for as long as `margin_n_i` is 0.
- R5: After `margin_n_i` returns to 1, the outputs stay forced high for at least MARGIN_DLY cycles and take their true state within MARGIN_DLY+8 cycles.
- R6: A low pulse on `mrst_n_i` shorter than GLITCH_LEN cycles has no effect on `sys_rst_n_o`. A low level held for 100 cycles or more drives `sys_rst_n_o` to 0 within GLITCH_LEN+4 cycles. After its release, the full timeout of R2 applies.
- R7: A new cause that arrives while the timeout is running restarts the timeout from zero.
- R8: While `rst` is 1, `sys_rst_n_o` is 0 and all `rail_ok_o` bits are 1. After `rst` falls with all inputs good, one full timeout (R2 window) passes before `sys_rst_n_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_i | input | N_RAILS | Asynchronous undervoltage flags, bit i = 1 when rail i is low |
| mrst_n_i | input | 1 | Asynchronous active-low manual reset |
| margin_n_i | input | 1 | Asynchronous active-low margin override |
| rail_ok_o | output | N_RAILS | Per-rail status, 0 while that rail is flagged |
| sys_rst_n_o | output | 1 | Stretched active-low system reset |

## Verification
The hardest state to reach is the release of the margin override while a rail is still faulty. At that moment the forced-high outputs must hold for the whole settling delay and then fall to their true values. The stimulus raises a rail flag first, then enters margin and stirs the manual reset and rail flags inside it. It then restores a single faulty rail and releases margin, checking every cycle of the delay window and measuring when the true state appears. The restart of a running timeout is reached the same way: a second fault is injected partway through a count that is known to be in progress.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // synchronized control inputs
    typedef struct packed {
        logic mrst_n;
        logic margin_n;
    } ctl_t;

    // reset stretcher phases
    typedef enum logic [1:0] {
        ST_FAULT = 2'd0,
        ST_WAIT  = 2'd1,
        ST_GOOD  = 2'd2
    } stretch_st_e;

    // counter width able to hold values 0 .. v-1
    function automatic int cw(input int v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rsq_deglitch.sv
module rsq_deglitch #(
    parameter int LEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int CW = rsq_pkg::cw(LEN);

    logic [CW-1:0] run;

    // level is adopted only after LEN consecutive differing cycles
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b1;
            run <= '0;
        end else if (d != q) begin
            if (run == CW'(LEN - 1)) begin
                q   <= d;
                run <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end else begin
            run <= '0;
        end
    end
endmodule

// File: rtl/rsq_stretch.sv
module rsq_stretch #(
    parameter int DIV   = 1000,
    parameter int TICKS = 14000
) (
    input  logic clk,
    input  logic rst,
    input  logic cause,
    output logic active
);
    import rsq_pkg::*;

    localparam int PW = cw(DIV);
    localparam int TW = cw(TICKS);

    stretch_st_e   st;
    logic [PW-1:0] presc;
    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_WAIT;
            presc <= '0;
            ticks <= '0;
        end else if (cause) begin
            // any cause restarts the whole count, prescaler included
            st    <= ST_FAULT;
            presc <= '0;
            ticks <= '0;
        end else if (st != ST_GOOD) begin
            st <= ST_WAIT;
            if (presc == PW'(DIV - 1)) begin
                presc <= '0;
                if (ticks == TW'(TICKS - 1)) begin
                    st    <= ST_GOOD;
                    ticks <= '0;
                end else begin
                    ticks <= ticks + 1'b1;
                end
            end else begin
                presc <= presc + 1'b1;
            end
        end
    end

    assign active = (st != ST_GOOD);
endmodule

// File: rtl/rsq_margin.sv
module rsq_margin #(
    parameter int DLY = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic margin_n,
    output logic force_hi
);
    localparam int DW = rsq_pkg::cw(DLY);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            force_hi <= 1'b0;
            cnt      <= '0;
        end else if (!margin_n) begin
            force_hi <= 1'b1;
            cnt      <= '0;
        end else if (force_hi) begin
            if (cnt == DW'(DLY - 1)) begin
                force_hi <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rail_sup_top.sv
module rail_sup_top #(
    parameter int N_RAILS       = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int TICK_DIV      = 1000,
    parameter int TIMEOUT_TICKS = 14000,
    parameter int GLITCH_LEN    = 10,
    parameter int MARGIN_DLY    = 2000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_RAILS-1:0] uv_i,
    input  logic               mrst_n_i,
    input  logic               margin_n_i,
    output logic [N_RAILS-1:0] rail_ok_o,
    output logic               sys_rst_n_o
);
    import rsq_pkg::*;

    logic [N_RAILS-1:0] uv_s;
    ctl_t               ctl_raw;
    ctl_t               ctl_s;
    logic               mrst_f;
    logic               cause;
    logic               stretch_act;
    logic               force_hi;
    logic [N_RAILS-1:0] rail_nxt;
    logic [N_RAILS-1:0] rail_q;
    logic               sys_q;

    assign ctl_raw = '{mrst_n: mrst_n_i, margin_n: margin_n_i};

    rsq_sync #(.W(N_RAILS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_uv (
        .clk(clk), .rst(rst), .d(uv_i), .q(uv_s)
    );

    rsq_sync #(.W($bits(ctl_t)), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_ctl (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
    );

    rsq_deglitch #(.LEN(GLITCH_LEN)) u_mr_filt (
        .clk(clk), .rst(rst), .d(ctl_s.mrst_n), .q(mrst_f)
    );

    assign cause = (|uv_s) | ~mrst_f;

    rsq_stretch #(.DIV(TICK_DIV), .TICKS(TIMEOUT_TICKS)) u_stretch (
        .clk(clk), .rst(rst), .cause(cause), .active(stretch_act)
    );

    rsq_margin #(.DLY(MARGIN_DLY)) u_margin (
        .clk(clk), .rst(rst), .margin_n(ctl_s.margin_n), .force_hi(force_hi)
    );

    for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
        assign rail_nxt[i] = force_hi | ~uv_s[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rail_q <= '1;
            sys_q  <= 1'b0;
        end else begin
            rail_q <= rail_nxt;
            sys_q  <= force_hi | ~(stretch_act | cause);
        end
    end

    assign rail_ok_o   = rail_q;
    assign sys_rst_n_o = sys_q;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
    parameter int N_RAILS = 4,
    parameter int TOTAL   = 14000000,
    parameter int GLITCH  = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               margin_s,
    input logic               force_hi,
    input logic               cause,
    input logic               mrst_s,
    input logic               mrst_f,
    input logic [N_RAILS-1:0] rail_ok_o,
    input logic               sys_rst_n_o
);
    int clr_run;
    int low_run;

    always_ff @(posedge clk) begin
        if (rst || cause) clr_run <= 0;
        else if (clr_run < TOTAL) clr_run <= clr_run + 1;
        if (rst || mrst_s) low_run <= 0;
        else if (low_run < GLITCH) low_run <= low_run + 1;
    end

    // R4
    margin_force_chk: assert property (@(posedge clk) disable iff (rst)
        !margin_s |-> ##2 ((&rail_ok_o) && sys_rst_n_o));

    // R3
    rail_implies_rst_chk: assert property (@(posedge clk) disable iff (rst)
        !(&rail_ok_o) |-> !sys_rst_n_o);

    // R2
    stretch_min_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sys_rst_n_o) && !$past(force_hi)) |-> (clr_run >= TOTAL));

    // R6
    glitch_min_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mrst_f) |-> (low_run >= GLITCH));
endmodule

bind rail_sup_top rsq_chk #(
    .N_RAILS(N_RAILS),
    .TOTAL(TICK_DIV * TIMEOUT_TICKS),
    .GLITCH(GLITCH_LEN)
) chk_i (
    .clk(clk),
    .rst(rst),
    .margin_s(ctl_s.margin_n),
    .force_hi(force_hi),
    .cause(cause),
    .mrst_s(ctl_s.mrst_n),
    .mrst_f(mrst_f),
    .rail_ok_o(rail_ok_o),
    .sys_rst_n_o(sys_rst_n_o)
);

// File: tb/rail_sup_top_tb_top.sv
module rail_sup_top_tb_top;
    localparam int N   = 4;
    localparam int DIV = 10;
    localparam int TK  = 20;
    localparam int GL  = 8;
    localparam int MD  = 50;
    localparam int TOT = DIV * TK;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] uv_i = '0;
    logic         mrst_n_i = 1'b1;
    logic         margin_n_i = 1'b1;
    logic [N-1:0] rail_ok_o;
    logic         sys_rst_n_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rail_sup_top #(
        .N_RAILS(N), .SYNC_STAGES(2), .TICK_DIV(DIV), .TIMEOUT_TICKS(TK),
        .GLITCH_LEN(GL), .MARGIN_DLY(MD)
    ) dut_i (
        .clk(clk), .rst(rst), .uv_i(uv_i), .mrst_n_i(mrst_n_i),
        .margin_n_i(margin_n_i), .rail_ok_o(rail_ok_o), .sys_rst_n_o(sys_rst_n_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_sys(input logic v, input int max, output int n);
        n = 0;
        while (sys_rst_n_o !== v && n < max) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_power_on();
        int n;
        cyc(5);
        chk(sys_rst_n_o == 1'b0, "R8 reset low in rst", sys_rst_n_o, 0);
        chk(rail_ok_o == '1, "R8 rails high in rst", rail_ok_o, 15);
        rst = 1'b0;
        wait_sys(1'b1, TOT + 50, n);
        chk(n >= TOT && n <= TOT + 8, "R8 power-on timeout", n, TOT);
    endtask

    task automatic t_rails(input logic [N-1:0] pat);
        int n;
        uv_i = pat;
        cyc(4);
        chk(rail_ok_o == ~pat, "R3 rail follows flag", rail_ok_o, int'(~pat));
        chk(sys_rst_n_o == 1'b0, "R1 reset on fault", sys_rst_n_o, 0);
        uv_i = '0;
        cyc(4);
        chk(rail_ok_o == '1, "R3 rail recovers unstretched", rail_ok_o, 15);
        chk(sys_rst_n_o == 1'b0, "R2 reset still held", sys_rst_n_o, 0);
        wait_sys(1'b1, TOT + 50, n);
        n += 4;
        chk(n >= TOT && n <= TOT + 8, "R2 timeout length", n, TOT);
    endtask

    task automatic t_restart();
        int n;
        uv_i = 4'b0001;
        cyc(10);
        uv_i = '0;
        cyc(100);
        chk(sys_rst_n_o == 1'b0, "R7 mid-timeout low", sys_rst_n_o, 0);
        uv_i = 4'b0100;
        cyc(10);
        uv_i = '0;
        wait_sys(1'b1, TOT + 50, n);
        chk(n >= TOT && n <= TOT + 8, "R7 restarted timeout", n, TOT);
    endtask

    task automatic t_manual();
        int n;
        int lows;
        lows = 0;
        mrst_n_i = 1'b0;
        cyc(GL - 1);
        mrst_n_i = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!sys_rst_n_o) lows++;
        end
        chk(lows == 0, "R6 short pulse ignored", lows, 0);
        mrst_n_i = 1'b0;
        cyc(GL + 4);
        chk(sys_rst_n_o == 1'b0, "R6 long pulse honoured", sys_rst_n_o, 0);
        cyc(100 - GL - 4);
        mrst_n_i = 1'b1;
        wait_sys(1'b1, TOT + 60, n);
        chk(n >= TOT + GL && n <= TOT + GL + 8, "R6 timeout after manual", n, TOT + GL);
    endtask

    task automatic t_margin();
        int n;
        int bad;
        bad = 0;
        uv_i = 4'b0001;
        cyc(4);
        chk(rail_ok_o == 4'b1110 && !sys_rst_n_o, "R3 rail0 fault before margin", rail_ok_o, 14);
        margin_n_i = 1'b0;
        cyc(4);
        chk(rail_ok_o == '1 && sys_rst_n_o, "R4 margin forces high", {sys_rst_n_o, rail_ok_o}, 31);
        for (int k = 0; k < 30; k++) begin
            uv_i = (k < 15) ? 4'b1111 : 4'b0001;
            mrst_n_i = (k >= 5 && k < 25) ? 1'b0 : 1'b1;
            @(negedge clk);
            if (rail_ok_o != '1 || !sys_rst_n_o) bad++;
        end
        chk(bad == 0, "R4 held while margin", bad, 0);
        cyc(20);
        margin_n_i = 1'b1;
        for (int k = 0; k < MD; k++) begin
            @(negedge clk);
            if (rail_ok_o != '1 || !sys_rst_n_o) bad++;
        end
        chk(bad == 0, "R5 forced through delay", bad, 0);
        n = MD;
        while (rail_ok_o[0] !== 1'b0 && n < MD + 40) begin
            @(negedge clk);
            n++;
        end
        chk(n >= MD && n <= MD + 8, "R5 true state after delay", n, MD);
        chk(rail_ok_o == 4'b1110 && !sys_rst_n_o, "R5 true values", {sys_rst_n_o, rail_ok_o}, 14);
        uv_i = '0;
        wait_sys(1'b1, TOT + 50, n);
        chk(sys_rst_n_o == 1'b1, "R2 release after margin test", sys_rst_n_o, 1);
    endtask

    initial begin
        #1ms;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_power_on();
        t_rails(4'b0010);
        t_rails(4'b1001);
        t_rails(4'b1111);
        t_restart();
        t_manual();
        t_margin();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule